// File: doc/BRIEF.md
# Tag-Matched Dataflow Firing Unit

This block is a single dataflow execution element. Nothing inside it counts through a program; an instruction runs as soon as all of its operands are present. Operand tokens enter through a valid/ready input into a small queue. Each token carries an 8-bit value, a 4-bit tag that names the instruction that will consume it, and a side bit that marks it as the left (0) or right (1) operand. The matching stage compares the tag of the token at the queue head with every occupied slot of an associative holding store. A token with no partner waits in a free slot. When its partner arrives, the slot is released and the pair fires.

A fired operand set reads its instruction from a fixed program table indexed by tag and passes through a small ALU. The result leaves as one or two new tokens, each stamped with a destination tag and side bit taken from the table. Instructions that take a single operand fire at once from the queue head and never occupy a slot. If the holding store is full and the head token has no partner, the head waits. The queue then fills and input readiness drops, so no token is ever lost. Output tokens are presented for one cycle each and have no ready signal.

Top module: `df_match_unit`

## Requirements
- R1: After reset is released, in_ready is 1 and out_valid is 0, and the holding store is empty.
- R2: The built-in program uses opcode = tag modulo 8: 0 add, 1 subtract (left minus right), 2 AND, 3 OR, 4 XOR, 5 increment, 6 pass, 7 double (shift left by 1). Opcodes 0 to 4 take two operands. Two tokens with the same dyadic tag and opposite side bits fire once and produce the opcode's result modulo 256, with the side-0 token as the left operand.
- R3: For subtract, the result is always side-0 value minus side-1 value, whichever of the two arrives first.
- R4: A dyadic token without a partner produces no output, however long it waits. Its partner arriving later makes the pair fire.
- R5: Opcodes 5 to 7 take one operand and fire on a single token without entering the holding store. The first result token is visible after the second rising edge that follows the edge at which the input was accepted.
- R6: Every tag t other than 15 sends its result to tag (t+1) mod 16 with side 0. An odd tag t also sends the same value to tag (t+3) mod 16 with side 1, on the cycle right after the first token.
- R7: Tag 15 (double) is a sink and emits no token.
- R8: When all holding slots are occupied and the head token has no partner, the head is not consumed and the unit produces no output.
- R9: The store is associative. Held tokens fire in the order their partners arrive, not in the order they were stored.
- R10: in_ready is 0 exactly while the input queue is full, and a token offered while in_ready is 0 is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input token offered |
| in_ready | output | 1 | Unit can take a token this cycle |
| in_tag | input | 4 | Consuming instruction of the input token |
| in_port | input | 1 | Operand side: 0 left, 1 right |
| in_value | input | 8 | Operand value |
| out_valid | output | 1 | Result token present this cycle |
| out_tag | output | 4 | Destination instruction of the result |
| out_port | output | 1 | Destination operand side |
| out_value | output | 8 | Result value |

## Verification
The hardest state to reach from the ports is backpressure. It needs every holding slot taken by tokens still waiting for partners, plus a head token that matches none of them. The stimulus sends four left operands with distinct dyadic tags, then four more unmatched dyadic tokens, so the queue fills behind a stuck head. It then checks that readiness is low, that a further offer is refused, and that no output appears. Reset clears the resulting deadlock, and a fresh pair proves the store came back empty. A separate scenario fills the store and then sends the partners in a shuffled order, so that the associative search is exercised.

// File: rtl/df_pkg.sv
// Shared widths, token and instruction types, and the built-in program.
// Assumes tags index the program table directly.
package df_pkg;
    parameter int TAG_W     = 4;
    parameter int DATA_W    = 8;
    parameter int OPC_W     = 3;
    parameter int NUM_INSTR = 1 << TAG_W;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef enum logic [OPC_W-1:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_INC  = 3'd5,
        OP_PASS = 3'd6,
        OP_DBL  = 3'd7
    } opcode_t;

    typedef struct packed {
        tag_t  tag;
        logic  port;
        data_t value;
    } token_t;

    typedef struct packed {
        logic vld;
        tag_t tag;
        logic port;
    } dest_t;

    typedef struct packed {
        opcode_t op;
        dest_t   d0;
        dest_t   d1;
    } instr_t;

    // Built-in program entry for one tag.
    function automatic instr_t prog_entry(input tag_t t);
        instr_t r;
        r.op      = opcode_t'(t[OPC_W-1:0]);
        r.d0.vld  = (t != tag_t'(NUM_INSTR - 1));
        r.d0.tag  = t + tag_t'(1);
        r.d0.port = 1'b0;
        r.d1.vld  = t[0] && (t != tag_t'(NUM_INSTR - 1));
        r.d1.tag  = t + tag_t'(3);
        r.d1.port = 1'b1;
        return r;
    endfunction

    // True for opcodes that consume a single operand.
    function automatic logic single_operand(input opcode_t op);
        return (op == OP_INC) || (op == OP_PASS) || (op == OP_DBL);
    endfunction
endpackage

// File: rtl/df_token_fifo.sv
// Token queue: circular buffer with valid/ready on the write side.
// The head is visible combinationally; pop is honoured only when a token is present.
// Assumes DEPTH is a power of two.
module df_token_fifo
    import df_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   push_valid,
    output logic   push_ready,
    input  token_t push_tok,
    output logic   head_valid,
    input  logic   pop,
    output token_t head_tok
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    token_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             do_push;
    logic             do_pop;

    assign push_ready = (count != CNT_W'(DEPTH));
    assign head_valid = (count != '0);
    assign head_tok   = mem[rd_ptr];
    assign do_push    = push_valid && push_ready;
    assign do_pop     = pop && head_valid;

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + PTR_W'(1);
            end
            if (do_push && !do_pop) begin
                count <= count + CNT_W'(1);
            end else if (do_pop && !do_push) begin
                count <= count - CNT_W'(1);
            end
        end
    end

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_tok;
        end
    end
endmodule

// File: rtl/df_prog_rom.sv
// Program store: a fixed table built from the package program function.
// Two independent combinational read ports.
module df_prog_rom
    import df_pkg::*;
(
    input  tag_t   addr_a,
    output instr_t data_a,
    input  tag_t   addr_b,
    output instr_t data_b
);
    instr_t table_q [NUM_INSTR];

    for (genvar i = 0; i < NUM_INSTR; i++) begin : g_entry
        assign table_q[i] = prog_entry(tag_t'(i));
    end

    assign data_a = table_q[addr_a];
    assign data_b = table_q[addr_b];
endmodule

// File: rtl/df_match_store.sv
// Associative matching store and firing decision for the queue head.
// A single-operand head fires directly. A dyadic head either pairs with a held
// token of equal tag (freeing its slot) or takes a free slot. The head stalls if
// it would fire while the execute stage is busy, or needs a slot and none is free.
// Assumes a held token and its partner carry opposite side bits.
module df_match_store
    import df_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     head_valid,
    input  token_t                   head_tok,
    input  logic                     head_single,
    input  logic                     fire_ready,
    output logic                     head_pop,
    output logic                     fire_go,
    output tag_t                     fire_tag,
    output data_t                    fire_left,
    output data_t                    fire_right,
    output logic [ENTRIES-1:0]       held_vld,
    output logic [ENTRIES*TAG_W-1:0] held_tags
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    token_t             slot [ENTRIES];
    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   hit_idx;
    logic [IDX_W-1:0]   free_idx;
    logic               hit_any;
    logic               free_any;
    logic               do_insert;
    logic               do_clear;
    token_t             partner;

    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        assign hit_vec[i] = vld[i] && (slot[i].tag == head_tok.tag);
        assign held_tags[i*TAG_W +: TAG_W] = slot[i].tag;
    end
    assign held_vld = vld;

    // Lowest-index hit and lowest-index free slot.
    always_comb begin
        hit_any  = 1'b0;
        free_any = 1'b0;
        hit_idx  = '0;
        free_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit_vec[i]) begin
                hit_any = 1'b1;
                hit_idx = IDX_W'(i);
            end
            if (!vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

    assign partner = slot[hit_idx];

    // Firing, insertion and pop decision for the head token.
    always_comb begin
        fire_go    = 1'b0;
        do_insert  = 1'b0;
        do_clear   = 1'b0;
        fire_tag   = head_tok.tag;
        fire_left  = head_tok.value;
        fire_right = '0;
        if (head_valid) begin
            if (head_single) begin
                fire_go = fire_ready;
            end else if (hit_any) begin
                fire_go  = fire_ready;
                do_clear = fire_ready;
                if (head_tok.port) begin
                    fire_left  = partner.value;
                    fire_right = head_tok.value;
                end else begin
                    fire_right = partner.value;
                end
            end else if (free_any) begin
                do_insert = 1'b1;
            end
        end
        head_pop = fire_go || do_insert;
    end

    // Slot occupancy updates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld <= '0;
        end else begin
            if (do_clear) begin
                vld[hit_idx] <= 1'b0;
            end
            if (do_insert) begin
                vld[free_idx] <= 1'b1;
            end
        end
    end

    // Slot payload capture on insertion.
    always_ff @(posedge clk) begin
        if (do_insert) begin
            slot[free_idx] <= head_tok;
        end
    end
endmodule

// File: rtl/df_exec_emit.sv
// Execute and token formation. Holds one fired operand set, computes the ALU
// result from the fetched instruction and emits one token per cycle. A second
// destination is emitted on the following cycle, during which the fired stage
// waits. Assumes the instruction input is the entry for fire_tag_o.
module df_exec_emit
    import df_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   fire_go,
    input  tag_t   fire_tag,
    input  data_t  fire_left,
    input  data_t  fire_right,
    input  instr_t fire_instr,
    output logic   fire_ready,
    output logic   fire_vld_o,
    output tag_t   fire_tag_o,
    output logic   out_valid,
    output token_t out_tok
);
    logic   fire_vld;
    tag_t   f_tag;
    data_t  f_left;
    data_t  f_right;
    data_t  result;
    logic   take;
    logic   pend_vld;
    dest_t  pend_dest;
    data_t  pend_val;
    logic   em_vld;
    token_t em_tok;

    assign take       = fire_vld && !pend_vld;
    assign fire_ready = !fire_vld || take;
    assign fire_vld_o = fire_vld;
    assign fire_tag_o = f_tag;
    assign out_valid  = em_vld;
    assign out_tok    = em_tok;

    // ALU for the fetched opcode.
    always_comb begin
        unique case (fire_instr.op)
            OP_ADD:  result = f_left + f_right;
            OP_SUB:  result = f_left - f_right;
            OP_AND:  result = f_left & f_right;
            OP_OR:   result = f_left | f_right;
            OP_XOR:  result = f_left ^ f_right;
            OP_INC:  result = f_left + data_t'(1);
            OP_PASS: result = f_left;
            OP_DBL:  result = {f_left[DATA_W-2:0], 1'b0};
            default: result = '0;
        endcase
    end

    // Fired operand register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fire_vld <= 1'b0;
            f_tag    <= '0;
            f_left   <= '0;
            f_right  <= '0;
        end else if (fire_go) begin
            fire_vld <= 1'b1;
            f_tag    <= fire_tag;
            f_left   <= fire_left;
            f_right  <= fire_right;
        end else if (take) begin
            fire_vld <= 1'b0;
        end
    end

    // Result token formation, one token per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            em_vld    <= 1'b0;
            em_tok    <= '0;
            pend_vld  <= 1'b0;
            pend_dest <= '0;
            pend_val  <= '0;
        end else if (pend_vld) begin
            em_vld   <= 1'b1;
            em_tok   <= '{tag: pend_dest.tag, port: pend_dest.port, value: pend_val};
            pend_vld <= 1'b0;
        end else if (take) begin
            if (fire_instr.d0.vld) begin
                em_vld    <= 1'b1;
                em_tok    <= '{tag: fire_instr.d0.tag, port: fire_instr.d0.port, value: result};
                pend_vld  <= fire_instr.d1.vld;
                pend_dest <= fire_instr.d1;
                pend_val  <= result;
            end else if (fire_instr.d1.vld) begin
                em_vld <= 1'b1;
                em_tok <= '{tag: fire_instr.d1.tag, port: fire_instr.d1.port, value: result};
            end else begin
                em_vld <= 1'b0;
            end
        end else begin
            em_vld <= 1'b0;
        end
    end
endmodule

// File: rtl/df_match_unit.sv
// Top of the dataflow firing unit: token queue, matching store, program store
// and execute/emit stage. Latency from acceptance to first result is two edges
// after the accepting edge. Outputs carry no ready; the consumer must accept.
module df_match_unit
    import df_pkg::*;
#(
    parameter int FIFO_DEPTH    = 4,
    parameter int STORE_ENTRIES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [TAG_W-1:0]  in_tag,
    input  logic              in_port,
    input  logic [DATA_W-1:0] in_value,
    output logic              out_valid,
    output logic [TAG_W-1:0]  out_tag,
    output logic              out_port,
    output logic [DATA_W-1:0] out_value
);
    token_t                         in_tok;
    token_t                         head_tok;
    token_t                         res_tok;
    logic                           head_valid;
    logic                           head_pop;
    instr_t                         head_instr;
    instr_t                         exec_instr;
    logic                           fire_go;
    logic                           fire_ready;
    logic                           fire_vld_o;
    tag_t                           fire_tag;
    tag_t                           fire_tag_o;
    data_t                          fire_left;
    data_t                          fire_right;
    logic [STORE_ENTRIES-1:0]       held_vld;
    logic [STORE_ENTRIES*TAG_W-1:0] held_tags;

    assign in_tok = '{tag: in_tag, port: in_port, value: in_value};

    df_token_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (in_valid),
        .push_ready (in_ready),
        .push_tok   (in_tok),
        .head_valid (head_valid),
        .pop        (head_pop),
        .head_tok   (head_tok)
    );

    df_prog_rom u_rom (
        .addr_a (head_tok.tag),
        .data_a (head_instr),
        .addr_b (fire_tag_o),
        .data_b (exec_instr)
    );

    df_match_store #(.ENTRIES(STORE_ENTRIES)) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .head_valid  (head_valid),
        .head_tok    (head_tok),
        .head_single (single_operand(head_instr.op)),
        .fire_ready  (fire_ready),
        .head_pop    (head_pop),
        .fire_go     (fire_go),
        .fire_tag    (fire_tag),
        .fire_left   (fire_left),
        .fire_right  (fire_right),
        .held_vld    (held_vld),
        .held_tags   (held_tags)
    );

    df_exec_emit u_exec (
        .clk        (clk),
        .rst_n      (rst_n),
        .fire_go    (fire_go),
        .fire_tag   (fire_tag),
        .fire_left  (fire_left),
        .fire_right (fire_right),
        .fire_instr (exec_instr),
        .fire_ready (fire_ready),
        .fire_vld_o (fire_vld_o),
        .fire_tag_o (fire_tag_o),
        .out_valid  (out_valid),
        .out_tok    (res_tok)
    );

    assign out_tag   = res_tok.tag;
    assign out_port  = res_tok.port;
    assign out_value = res_tok.value;
endmodule

// File: rtl/df_match_checker.sv
// Temporal checks on the firing unit, attached to every instance by bind.
module df_match_checker
    import df_pkg::*;
#(
    parameter int ENTRIES = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     out_valid,
    input logic [TAG_W-1:0]         out_tag,
    input logic                     out_port,
    input logic [ENTRIES-1:0]       held_vld,
    input logic [ENTRIES*TAG_W-1:0] held_tags,
    input logic                     fire_vld_o,
    input logic                     fire_ready,
    input logic [TAG_W-1:0]         fire_tag_o
);
    logic held_single;

    // Flags any occupied slot whose tag names a single-operand instruction.
    always_comb begin
        held_single = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (held_vld[i] && single_operand(prog_entry(held_tags[i*TAG_W +: TAG_W]).op)) begin
                held_single = 1'b1;
            end
        end
    end

    AST_SECOND_DEST_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_port && !out_tag[0]) |=>
        (out_valid && out_port && out_tag == $past(out_tag) + TAG_W'(2))); // R6

    AST_STORE_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(held_vld) <= $past($countones(held_vld)) + 1) &&
        ($countones(held_vld) + 1 >= $past($countones(held_vld)))); // R4

    AST_SINGLE_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !held_single); // R5

    AST_FIRE_HELD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_vld_o && !fire_ready) |=> (fire_vld_o && $stable(fire_tag_o))); // R8
endmodule

bind df_match_unit df_match_checker #(.ENTRIES(STORE_ENTRIES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .out_valid  (out_valid),
    .out_tag    (out_tag),
    .out_port   (out_port),
    .held_vld   (held_vld),
    .held_tags  (held_tags),
    .fire_vld_o (fire_vld_o),
    .fire_ready (fire_ready),
    .fire_tag_o (fire_tag_o)
);

// File: tb/sim_df_match_unit.sv
// Directed bench: one task per scenario, each checking its own results.
module sim_df_match_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] in_tag = '0;
    logic       in_port = 1'b0;
    logic [7:0] in_value = '0;
    logic       out_valid;
    logic [3:0] out_tag;
    logic       out_port;
    logic [7:0] out_value;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int acc_cyc = 0;
    int obs_n = 0;
    logic [3:0] obs_tag [64];
    logic       obs_port [64];
    logic [7:0] obs_val [64];
    int         obs_cyc [64];

    df_match_unit u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_tag(in_tag), .in_port(in_port), .in_value(in_value),
        .out_valid(out_valid), .out_tag(out_tag), .out_port(out_port), .out_value(out_value)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Records every result token at the falling edge.
    always @(negedge clk) begin
        if (rst_n && out_valid && obs_n < 64) begin
            obs_tag[obs_n]  = out_tag;
            obs_port[obs_n] = out_port;
            obs_val[obs_n]  = out_value;
            obs_cyc[obs_n]  = cyc;
            obs_n = obs_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_alu(input logic [3:0] t, input logic [7:0] l, input logic [7:0] r);
        case (t % 8)
            0: return l + r;
            1: return l - r;
            2: return l & r;
            3: return l | r;
            4: return l ^ r;
            5: return l + 8'd1;
            6: return l;
            default: return {l[6:0], 1'b0};
        endcase
    endfunction

    // Offers one token and waits until it is taken; starts and ends at a falling edge.
    task automatic send(input logic [3:0] t, input logic p, input logic [7:0] v);
        bit rdy;
        in_valid = 1'b1; in_tag = t; in_port = p; in_value = v;
        forever begin
            rdy = in_ready;
            @(posedge clk);
            if (rdy) break;
            @(negedge clk);
        end
        @(negedge clk);
        acc_cyc = cyc;
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Checks observed token idx against the expected fields.
    task automatic expect_tok(input int idx, input logic [3:0] t, input logic p, input logic [7:0] v, input string req);
        chk(obs_n > idx, req, "token present", obs_n, idx + 1);
        if (obs_n > idx) begin
            chk(obs_tag[idx] == t, req, "tag", obs_tag[idx], t);
            chk(obs_port[idx] == p, req, "port", obs_port[idx], p);
            chk(obs_val[idx] == v, req, "value", obs_val[idx], v);
        end
    endtask

    // Expected result tokens of a firing on tag t with the given result.
    task automatic expect_fire(inout int idx, input logic [3:0] t, input logic [7:0] res, input string req);
        expect_tok(idx, t + 4'd1, 1'b0, res, req);
        idx++;
        if (t[0]) begin
            expect_tok(idx, t + 4'd3, 1'b1, res, req);
            idx++;
        end
    endtask

    task automatic do_reset;
        @(negedge clk);
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        obs_n = 0;
    endtask

    task automatic t_reset;
        do_reset();
        chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
    endtask

    task automatic t_single_latency;
        int idx = 0;
        obs_n = 0;
        send(4'd5, 1'b0, 8'h10);
        idle(6);
        expect_fire(idx, 4'd5, 8'h11, "R5");
        chk(obs_n == 2, "R6", "token count tag5", obs_n, 2);
        if (obs_n == 2) begin
            chk(obs_cyc[0] == acc_cyc + 2, "R5", "first result cycle", obs_cyc[0], acc_cyc + 2);
            chk(obs_cyc[1] == obs_cyc[0] + 1, "R6", "second result cycle", obs_cyc[1], obs_cyc[0] + 1);
        end
        idx = 0; obs_n = 0;
        send(4'd6, 1'b0, 8'hA5);
        idle(6);
        expect_fire(idx, 4'd6, 8'hA5, "R5");
        chk(obs_n == 1, "R6", "even tag single token", obs_n, 1);
    endtask

    task automatic t_pairs;
        int idx = 0;
        obs_n = 0;
        send(4'd0, 1'b0, 8'd200);
        send(4'd0, 1'b1, 8'd100);
        send(4'd2, 1'b1, 8'h3C);
        send(4'd2, 1'b0, 8'hF5);
        send(4'd4, 1'b0, 8'hFF);
        send(4'd4, 1'b1, 8'h0F);
        send(4'd3, 1'b0, 8'h81);
        send(4'd3, 1'b1, 8'h18);
        idle(8);
        expect_fire(idx, 4'd0, ref_alu(4'd0, 8'd200, 8'd100), "R2");
        expect_fire(idx, 4'd2, ref_alu(4'd2, 8'hF5, 8'h3C), "R2");
        expect_fire(idx, 4'd4, ref_alu(4'd4, 8'hFF, 8'h0F), "R2");
        expect_fire(idx, 4'd3, ref_alu(4'd3, 8'h81, 8'h18), "R2");
        chk(obs_n == idx, "R2", "token count pairs", obs_n, idx);
    endtask

    task automatic t_sub_order;
        int idx = 0;
        obs_n = 0;
        send(4'd1, 1'b1, 8'd5);
        send(4'd1, 1'b0, 8'd20);
        send(4'd9, 1'b0, 8'd3);
        send(4'd9, 1'b1, 8'd10);
        idle(8);
        expect_fire(idx, 4'd1, 8'd15, "R3");
        expect_fire(idx, 4'd9, 8'hF9, "R3");
        chk(obs_n == idx, "R3", "token count sub", obs_n, idx);
    endtask

    task automatic t_wait_partner;
        int idx = 0;
        obs_n = 0;
        send(4'd10, 1'b0, 8'hF0);
        idle(12);
        chk(obs_n == 0, "R4", "no output while waiting", obs_n, 0);
        send(4'd10, 1'b1, 8'h3C);
        idle(6);
        expect_fire(idx, 4'd10, 8'h30, "R4");
        chk(obs_n == 1, "R4", "token count after partner", obs_n, 1);
    endtask

    task automatic t_sink;
        int idx = 0;
        obs_n = 0;
        send(4'd15, 1'b0, 8'h41);
        idle(8);
        chk(obs_n == 0, "R7", "sink emits nothing", obs_n, 0);
        send(4'd7, 1'b0, 8'h41);
        idle(6);
        expect_fire(idx, 4'd7, 8'h82, "R7");
    endtask

    task automatic t_assoc;
        int idx = 0;
        obs_n = 0;
        send(4'd3, 1'b0, 8'h11);
        send(4'd4, 1'b0, 8'h22);
        send(4'd11, 1'b0, 8'h44);
        send(4'd12, 1'b0, 8'h88);
        idle(4);
        chk(obs_n == 0, "R9", "all held", obs_n, 0);
        send(4'd12, 1'b1, 8'h0F);
        send(4'd3, 1'b1, 8'h06);
        send(4'd11, 1'b1, 8'h01);
        send(4'd4, 1'b1, 8'h22);
        idle(10);
        expect_fire(idx, 4'd12, 8'h87, "R9");
        expect_fire(idx, 4'd3, 8'h17, "R9");
        expect_fire(idx, 4'd11, 8'h45, "R9");
        expect_fire(idx, 4'd4, 8'h00, "R9");
        chk(obs_n == idx, "R9", "token count assoc", obs_n, idx);
    endtask

    task automatic t_backpressure;
        int idx = 0;
        bit taken = 1'b0;
        do_reset();
        send(4'd0, 1'b0, 8'd1);
        send(4'd1, 1'b0, 8'd2);
        send(4'd2, 1'b0, 8'd3);
        send(4'd3, 1'b0, 8'd4);
        send(4'd4, 1'b0, 8'd5);
        send(4'd8, 1'b0, 8'd6);
        send(4'd9, 1'b0, 8'd7);
        send(4'd10, 1'b0, 8'd8);
        idle(3);
        chk(in_ready == 1'b0, "R10", "in_ready low when queue full", in_ready, 0);
        in_valid = 1'b1; in_tag = 4'd0; in_port = 1'b1; in_value = 8'd9;
        repeat (6) begin
            if (in_ready) taken = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0;
        chk(taken == 1'b0, "R10", "offer refused while full", taken, 0);
        idle(6);
        chk(obs_n == 0, "R8", "no output while stalled", obs_n, 0);
        chk(in_ready == 1'b0, "R8", "still stalled", in_ready, 0);
        do_reset();
        chk(in_ready == 1'b1, "R1", "in_ready after recovery", in_ready, 1);
        send(4'd0, 1'b1, 8'd50);
        idle(6);
        chk(obs_n == 0, "R1", "store empty after reset", obs_n, 0);
        send(4'd0, 1'b0, 8'd7);
        idle(6);
        expect_fire(idx, 4'd0, 8'd57, "R1");
    endtask

    initial begin
        t_reset();
        t_single_latency();
        t_pairs();
        t_sub_order();
        t_wait_partner();
        t_sink();
        t_assoc();
        t_backpressure();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule